// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Flag

This block is the storage stage on the receive side of a serial port. Each byte that the deserializer completes arrives with a push strobe and a one-bit parity error tag. The block keeps byte and tag together in a first-in first-out store of 64 entries. The oldest entry is always visible to the processor on a read port, and a read strobe removes that entry. A 7-bit level output reports how many bytes are waiting, from 0 to 64.

Software is signalled through a level-triggered "data ready" flag. The flag rises when the stored level reaches a threshold, and a 2-bit trigger field selects that threshold. The flag is sticky. It falls only under three conditions together:
- software has observed it as one through a status read,
- the level has since dropped below the threshold,
- software then writes a zero to it.

A separate parity status output follows the tag of the entry at the read head. It is not an accumulated error. A push that arrives when the store is full and nothing leaves in the same cycle is discarded, and it sets a sticky overrun indicator.

Top module: `rxq_top`

## Requirements
- R1: After reset the level is 0, the data-ready flag is 0, the parity status is 0, the overrun indicator is 0 and the read port shows 8'hFF.
- R2: Bytes leave in the order they were pushed. The read port shows the oldest stored byte, and a read strobe removes it in that clock edge. Up to 64 bytes are held.
- R3: The level rises by one on an accepted push alone, falls by one on an accepted read alone, stays the same when both happen in one cycle, and never exceeds 64.
- R4: A push at level 64 without a read in the same cycle is dropped. It leaves the stored data and the level unchanged and sets the overrun indicator. The indicator then stays 1 until reset. A push together with a read at level 64 is accepted.
- R5: A read strobe at level 0 does not change the level or the stored order. While the level is 0 the read port shows 8'hFF.
- R6: The trigger field maps 2'b00, 2'b01, 2'b10 and 2'b11 to thresholds of 1, 16, 32 and 48 bytes. The flag is 1 from the clock edge after the edge on which the level first equals or exceeds the threshold.
- R7: The flag goes to 0 on the clock edge of a status write with value 0, provided that a status read strobe was given while the flag was 1 since the flag last fell and that the level is below the threshold in that cycle.
- R8: A status write of 1 never changes the flag. A write of 0 with no qualifying status read is ignored. A write of 0 while the level is at or above the threshold is also ignored.
- R9: The parity status output equals the parity tag stored with the byte at the read head, and it is 0 while the store is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or manual) |
| push_i | input | 1 | Byte from the deserializer is valid this cycle |
| push_data_i | input | 8 | Received byte |
| push_perr_i | input | 1 | Parity error tag of the received byte |
| pop_i | input | 1 | Processor read strobe; removes the head byte |
| rd_data_o | output | 8 | Head byte, 8'hFF when empty |
| rd_perr_o | output | 1 | Parity tag of the head byte |
| level_o | output | 7 | Number of stored bytes |
| overrun_o | output | 1 | Sticky dropped-push indicator |
| trig_sel_i | input | 2 | Threshold select |
| status_rd_i | input | 1 | Processor reads the status flag this cycle |
| status_wr_i | input | 1 | Processor writes the status flag this cycle |
| status_wr_val_i | input | 1 | Value written to the flag |
| full_flag_o | output | 1 | Data-ready flag |

## Verification
The checker watches several properties on every cycle:
- the level stays within 0 to 64 and moves by exactly one step on a lone push or a lone read;
- a push into a full store is dropped and the overrun indicator stays set;
- the read port shows the idle pattern when empty;
- the flag rises whenever the level is at the threshold;
- the flag never falls except through a write of zero at a level below the threshold.

Some behaviour needs the directed scenarios in the bench:
- byte order and tag tracking through a full wrap of the store;
- the exact cycle on which the flag rises for each trigger encoding;
- whether a status read really arms the clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Threshold in bytes for each trigger select code, scaled from the depth.
    function automatic int unsigned trig_level(input logic [1:0] sel,
                                               input int unsigned depth);
        int unsigned lvl;
        case (sel)
            2'b00:   lvl = 1;
            2'b01:   lvl = depth / 4;
            2'b10:   lvl = depth / 2;
            default: lvl = (3 * depth) / 4;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] data_i,
    input  logic          perr_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_data_o,
    output logic          head_perr_o,
    output logic [CW-1:0] count_o,
    output logic          overrun_o
);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
        logic          ovr;
    } store_t;

    store_t st_d, st_q;
    logic [DW:0] mem_q [DEPTH];

    logic is_full, is_empty, do_pop, do_push;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d     = st_q;
        is_full  = (st_q.cnt == CW'(DEPTH));
        is_empty = (st_q.cnt == '0);
        do_pop   = pop_i && !is_empty;
        // A read in the same cycle frees one slot, so a full store still takes the byte.
        do_push  = push_i && (!is_full || do_pop);
        if (do_push) st_d.wr = ptr_inc(st_q.wr);
        if (do_pop)  st_d.rd = ptr_inc(st_q.rd);
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        if (push_i && !do_push) st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wr] <= {perr_i, data_i};
        end
    end

    always_comb begin
        if (is_empty) begin
            head_data_o = '1;
            head_perr_o = 1'b0;
        end else begin
            head_data_o = mem_q[st_q.rd][DW-1:0];
            head_perr_o = mem_q[st_q.rd][DW];
        end
    end

    assign count_o   = st_q.cnt;
    assign overrun_o = st_q.ovr;

endmodule

// File: rtl/rxq_flag.sv
module rxq_flag #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_i,
    input  logic [1:0]    trig_sel_i,
    input  logic          stat_rd_i,
    input  logic          stat_wr_i,
    input  logic          stat_wr_val_i,
    output logic          flag_o
);

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_t;

    flag_t fl_d, fl_q;
    logic [CW-1:0] thr;
    logic at_level, clr_ok;

    always_comb begin
        fl_d     = fl_q;
        thr      = CW'(rxq_pkg::trig_level(trig_sel_i, DEPTH));
        at_level = (count_i >= thr);
        clr_ok   = stat_wr_i && !stat_wr_val_i && fl_q.armed && !at_level;
        if (stat_rd_i && fl_q.flag) fl_d.armed = 1'b1;
        if (clr_ok) begin
            fl_d.flag  = 1'b0;
            fl_d.armed = 1'b0;
        end
        if (at_level) fl_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flag_o = fl_q.flag;

endmodule

// File: rtl/rxq_top.sv
module rxq_top #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          push_perr_i,
    input  logic          pop_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_perr_o,
    output logic [CW-1:0] level_o,
    output logic          overrun_o,
    input  logic [1:0]    trig_sel_i,
    input  logic          status_rd_i,
    input  logic          status_wr_i,
    input  logic          status_wr_val_i,
    output logic          full_flag_o
);

    logic [CW-1:0] count_w;

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .data_i      (push_data_i),
        .perr_i      (push_perr_i),
        .pop_i       (pop_i),
        .head_data_o (rd_data_o),
        .head_perr_o (rd_perr_o),
        .count_o     (count_w),
        .overrun_o   (overrun_o)
    );

    rxq_flag #(.DEPTH(DEPTH)) u_flag (
        .clk           (clk),
        .rst_n         (rst_n),
        .count_i       (count_w),
        .trig_sel_i    (trig_sel_i),
        .stat_rd_i     (status_rd_i),
        .stat_wr_i     (status_wr_i),
        .stat_wr_val_i (status_wr_val_i),
        .flag_o        (full_flag_o)
    );

    assign level_o = count_w;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic          pop_i,
    input logic [DW-1:0] rd_data_o,
    input logic          rd_perr_o,
    input logic [CW-1:0] level_o,
    input logic          overrun_o,
    input logic [1:0]    trig_sel_i,
    input logic          status_wr_i,
    input logic          status_wr_val_i,
    input logic          full_flag_o
);

    logic [CW-1:0] thr_w;
    assign thr_w = CW'(rxq_pkg::trig_level(trig_sel_i, DEPTH));

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= CW'(DEPTH));

    assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && level_o < CW'(DEPTH)) |=> (level_o == $past(level_o) + CW'(1)));

    assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && level_o != '0) |=> (level_o == $past(level_o) - CW'(1)));

    assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && level_o == CW'(DEPTH)) |=> (overrun_o && level_o == CW'(DEPTH)));

    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && level_o == '0) |=> (level_o == '0));

    // R5 and R9: idle view of the read port while nothing is stored
    assert_empty_view_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == '0) |-> (rd_data_o == '1 && !rd_perr_o));

    assert_trigger_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o >= thr_w) |=> full_flag_o);

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_flag_o && !(status_wr_i && !status_wr_val_i)) |=> full_flag_o);

    assert_no_clear_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_flag_o && level_o >= thr_w) |=> full_flag_o);

endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .push_i          (push_i),
    .pop_i           (pop_i),
    .rd_data_o       (rd_data_o),
    .rd_perr_o       (rd_perr_o),
    .level_o         (level_o),
    .overrun_o       (overrun_o),
    .trig_sel_i      (trig_sel_i),
    .status_wr_i     (status_wr_i),
    .status_wr_val_i (status_wr_val_i),
    .full_flag_o     (full_flag_o)
);

// File: tb/rxq_top_test.sv
`timescale 1ns/1ps
module rxq_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0;
    logic [7:0] push_data_i = '0;
    logic       push_perr_i = 1'b0;
    logic       pop_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       rd_perr_o;
    logic [6:0] level_o;
    logic       overrun_o;
    logic [1:0] trig_sel_i = '0;
    logic       status_rd_i = 1'b0;
    logic       status_wr_i = 1'b0;
    logic       status_wr_val_i = 1'b0;
    logic       full_flag_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    rxq_top uut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
        .push_perr_i(push_perr_i), .pop_i(pop_i), .rd_data_o(rd_data_o),
        .rd_perr_o(rd_perr_o), .level_o(level_o), .overrun_o(overrun_o),
        .trig_sel_i(trig_sel_i), .status_rd_i(status_rd_i), .status_wr_i(status_wr_i),
        .status_wr_val_i(status_wr_val_i), .full_flag_o(full_flag_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        push_i = 0; pop_i = 0; status_rd_i = 0; status_wr_i = 0; status_wr_val_i = 0;
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic push_byte(input logic [7:0] d, input logic p);
        push_i = 1; push_data_i = d; push_perr_i = p;
        tick();
        push_i = 0;
    endtask

    task automatic pop_expect(input logic [7:0] d, input logic p, input string req);
        chk(rd_data_o == d, req, rd_data_o, d);
        chk(rd_perr_o == p, "R9 head parity", rd_perr_o, p);
        pop_i = 1;
        tick();
        pop_i = 0;
    endtask

    task automatic stat_write(input logic v);
        status_wr_i = 1; status_wr_val_i = v;
        tick();
        status_wr_i = 0; status_wr_val_i = 0;
    endtask

    task automatic stat_read();
        status_rd_i = 1;
        tick();
        status_rd_i = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(level_o == 0, "R1 level", level_o, 0);
        chk(full_flag_o == 0, "R1 flag", full_flag_o, 0);
        chk(rd_perr_o == 0, "R1 parity", rd_perr_o, 0);
        chk(overrun_o == 0, "R1 overrun", overrun_o, 0);
        chk(rd_data_o == 8'hFF, "R1 read port", rd_data_o, 8'hFF);
    endtask

    task automatic t_order();
        do_reset();
        for (int i = 0; i < 5; i++) push_byte(8'h30 + 8'(i), i[0]);
        chk(level_o == 5, "R3 level after pushes", level_o, 5);
        for (int i = 0; i < 5; i++) pop_expect(8'h30 + 8'(i), i[0], "R2 order");
        chk(level_o == 0, "R3 level after drain", level_o, 0);
    endtask

    task automatic t_simul();
        do_reset();
        push_byte(8'hA1, 1'b1);
        chk(rd_data_o == 8'hA1, "R2 head", rd_data_o, 8'hA1);
        push_i = 1; push_data_i = 8'hB2; push_perr_i = 0; pop_i = 1;
        tick();
        push_i = 0; pop_i = 0;
        chk(level_o == 1, "R3 push+pop keeps level", level_o, 1);
        chk(rd_data_o == 8'hB2, "R2 push+pop order", rd_data_o, 8'hB2);
        chk(rd_perr_o == 0, "R9 tag follows head", rd_perr_o, 0);
    endtask

    task automatic t_empty_pop();
        do_reset();
        pop_i = 1;
        tick();
        pop_i = 0;
        chk(level_o == 0, "R5 level after empty read", level_o, 0);
        chk(rd_data_o == 8'hFF, "R5 empty pattern", rd_data_o, 8'hFF);
        chk(rd_perr_o == 0, "R9 empty parity", rd_perr_o, 0);
        push_byte(8'h11, 0);
        pop_expect(8'h11, 0, "R5 order intact after empty read");
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < 64; i++) push_byte(8'(i), i[2]);
        chk(level_o == 64, "R2 holds 64", level_o, 64);
        chk(overrun_o == 0, "R4 no overrun yet", overrun_o, 0);
        push_byte(8'hEE, 1);
        chk(level_o == 64, "R4 level after drop", level_o, 64);
        chk(overrun_o == 1, "R4 overrun set", overrun_o, 1);
        // push with a read at full is accepted
        push_i = 1; push_data_i = 8'h77; push_perr_i = 1; pop_i = 1;
        tick();
        push_i = 0; pop_i = 0;
        chk(level_o == 64, "R4 push+pop at full", level_o, 64);
        for (int i = 1; i < 64; i++) pop_expect(8'(i), i[2], "R2 wrap order");
        pop_expect(8'h77, 1, "R4 accepted byte at tail");
        chk(level_o == 0, "R3 drained", level_o, 0);
        chk(overrun_o == 1, "R4 overrun sticky", overrun_o, 1);
        do_reset();
        chk(overrun_o == 0, "R4 reset clears overrun", overrun_o, 0);
    endtask

    task automatic t_trig(input int sel);
        int thr;
        thr = (sel == 0) ? 1 : sel * 16;
        do_reset();
        trig_sel_i = 2'(sel);
        for (int i = 0; i < thr - 1; i++) push_byte(8'(i), 0);
        tick();
        chk(full_flag_o == 0, "R6 below threshold", full_flag_o, 0);
        push_byte(8'h5A, 0);
        chk(full_flag_o == 0, "R6 flag one edge late", full_flag_o, 0);
        tick();
        chk(full_flag_o == 1, "R6 flag at threshold", full_flag_o, 1);
        pop_i = 1; tick(); pop_i = 0;
        tick();
        chk(full_flag_o == 1, "R7 flag holds below threshold", full_flag_o, 1);
        stat_write(1);
        chk(full_flag_o == 1, "R8 write one ignored", full_flag_o, 1);
        stat_write(0);
        chk(full_flag_o == 1, "R8 write zero without read", full_flag_o, 1);
        stat_read();
        stat_write(0);
        chk(full_flag_o == 0, "R7 clear after read", full_flag_o, 0);
        tick();
        chk(full_flag_o == 0, "R7 stays clear", full_flag_o, 0);
        push_byte(8'h66, 0);
        tick();
        chk(full_flag_o == 1, "R6 set again", full_flag_o, 1);
        stat_read();
        stat_write(0);
        chk(full_flag_o == 1, "R8 write zero at threshold", full_flag_o, 1);
        pop_i = 1; tick(); pop_i = 0;
        stat_write(0);
        chk(full_flag_o == 0, "R7 clear after drop below", full_flag_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_simul();
        t_empty_pop();
        t_full();
        for (int s = 0; s < 4; s++) t_trig(s);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule